// File: doc/BRIEF.md
# Standards Select Hunt Controller

This block finds the serial data rate that the receive path can lock to. It drives a 2-bit rate-select code to the front end. While a carrier is present and no timing reference has been recognised, it moves the code to the next candidate after each hunt period. The code goes up in binary and wraps from 3 back to 0. The hunt period is a number of clock cycles. It is sampled once, just after reset, so each candidate rate gets the same dwell time.

Hunting pauses whenever the carrier is absent. Both the code and the dwell count are held, and the hunt carries on from that point when the carrier comes back. A valid timing-reference (TRS) pulse locks the code. While locked, every further TRS pulse restarts a lock timeout. If the timeout runs out with no TRS, the block drops back to hunting. It starts from the code it was holding and counts a full dwell period on that code.

Top module: `std_hunt_ctrl`

## Requirements
- R1: While rst_ni is low, ss_o is 0 and locked_o is 0. After release the block is hunting.
- R2: The hunt period P is the value of period_i in the first clock cycle after reset is released. Later changes to period_i have no effect until the next reset.
- R3: While hunting, with carrier_i high and trs_valid_i low, ss_o advances by one after every P rising edges, counting from reset release or from the most recent resume. A P of 0 is treated as 1.
- R4: From code 3, ss_o advances to code 0 and hunting continues.
- R5: While hunting with carrier_i low, ss_o and the dwell count hold. Once the carrier returns, the next step comes after the remaining cycles of the interrupted period.
- R6: If trs_valid_i is high at a rising edge, locked_o is high after that edge. This holds whether or not the carrier is present.
- R7: While locked, ss_o does not change for any value of carrier_i. A trs_valid_i pulse restarts the lock timeout.
- R8: After LOCK_TIMEOUT consecutive edges with no TRS following the last TRS, locked_o falls. Hunting then resumes from the held code, and the next step comes after a full P edges.
- R9: ss_o only ever changes to its previous value plus one, modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| carrier_i | input | 1 | High while a carrier is detected |
| trs_valid_i | input | 1 | One-cycle pulse per valid timing reference |
| period_i | input | PERIOD_W | Hunt dwell period in clock cycles, sampled after reset |
| ss_o | output | CODE_W | Rate select code |
| locked_o | output | 1 | High while the code is held by TRS lock |

## Verification
The assertions assume that carrier_i and trs_valid_i are synchronous to clk_i. They also assume that period_i is stable from reset assertion through the first cycle after release. The bench changes every input one time unit after a rising edge and samples outputs at the same point. This means no input change lands on an edge. The bench changes period_i only after the first post-reset edge, which tests that the sampled value is kept. Periods from 0 to 6 are swept, each over more than one full wrap of the code.

// File: rtl/std_hunt_pkg.sv
package std_hunt_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } hunt_state_e;
endpackage

// File: rtl/hunt_period_timer.sv
module hunt_period_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                clear_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                step_o
);
  logic [PERIOD_W-1:0] period_q;
  logic                loaded_q;
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] eff_period;

  // capture period on the first cycle after reset; use the live value in that cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      loaded_q <= 1'b0;
    end else if (!loaded_q) begin
      period_q <= period_i;
      loaded_q <= 1'b1;
    end
  end

  assign eff_period = loaded_q ? period_q : period_i;
  assign step_o = run_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, eff_period});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || step_o) cnt_q <= '0;
    else if (run_i)             cnt_q <= cnt_q + 1'b1;
  end

  p_step_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> cnt_q == '0);
  p_hold_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clear_i) |=> $stable(cnt_q));
  p_period_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |=> $stable(period_q));
endmodule

// File: rtl/lock_timeout.sv
module lock_timeout #(
  parameter int LOCK_TIMEOUT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic trs_i,
  output logic expire_o
);
  localparam int TO_W = $clog2(LOCK_TIMEOUT + 1);
  localparam logic [TO_W-1:0] LAST = TO_W'(LOCK_TIMEOUT - 1);

  logic [TO_W-1:0] cnt_q;

  assign expire_o = en_i && !trs_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!en_i || trs_i || expire_o) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  p_timeout_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= LAST);
  p_trs_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trs_i |=> cnt_q == '0);
endmodule

// File: rtl/ss_code_counter.sv
module ss_code_counter #(
  parameter int CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    code_o <= '0;
    else if (inc_i) code_o <= code_o + 1'b1; // natural wrap to 0
  end

  p_plus_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != $past(code_o)) |-> (code_o == CODE_W'($past(code_o) + 1'b1)));
endmodule

// File: rtl/std_hunt_ctrl.sv
module std_hunt_ctrl
  import std_hunt_pkg::*;
#(
  parameter int CODE_W       = 2,
  parameter int PERIOD_W     = 16,
  parameter int LOCK_TIMEOUT = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                carrier_i,
  input  logic                trs_valid_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [CODE_W-1:0]   ss_o,
  output logic                locked_o
);
  hunt_state_e state_q;
  logic        hunting;
  logic        run;
  logic        step;
  logic        expire;

  assign hunting  = (state_q == ST_HUNT);
  assign run      = hunting && carrier_i && !trs_valid_i;
  assign locked_o = (state_q == ST_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HUNT;
    else begin
      unique case (state_q)
        ST_HUNT: if (trs_valid_i) state_q <= ST_LOCK;
        ST_LOCK: if (expire)      state_q <= ST_HUNT;
        default:                  state_q <= ST_HUNT;
      endcase
    end
  end

  hunt_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .clear_i  (!hunting),
    .period_i (period_i),
    .step_o   (step)
  );

  lock_timeout #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_timeout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (locked_o),
    .trs_i    (trs_valid_i),
    .expire_o (expire)
  );

  ss_code_counter #(.CODE_W(CODE_W)) u_code (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (step),
    .code_o (ss_o)
  );

  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (ss_o == '0 && !locked_o));
  p_no_carrier_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carrier_i && !locked_o) |=> $stable(ss_o));
  p_trs_locks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trs_valid_i |=> locked_o);
  p_lock_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> $stable(ss_o));
endmodule

// File: tb/std_hunt_ctrl_test.sv
module std_hunt_ctrl_test;
  localparam int PW = 8;
  localparam int TO = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          carrier_i = 1'b0;
  logic          trs_valid_i = 1'b0;
  logic [PW-1:0] period_i = '0;
  logic [1:0]    ss_o;
  logic          locked_o;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  std_hunt_ctrl #(.CODE_W(2), .PERIOD_W(PW), .LOCK_TIMEOUT(TO)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .carrier_i   (carrier_i),
    .trs_valid_i (trs_valid_i),
    .period_i    (period_i),
    .ss_o        (ss_o),
    .locked_o    (locked_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input int p);
    rst_ni = 1'b0; carrier_i = 1'b1; trs_valid_i = 1'b0; period_i = PW'(p);
    tick(2);
    chk("R1 ss", ss_o, 0);
    chk("R1 locked", locked_o, 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R2/R3/R4: period sweep, period_i disturbed after the sampling cycle
    for (int p = 0; p <= 6; p++) begin
      int eff;
      eff = (p == 0) ? 1 : p;
      do_reset(p);
      for (int k = 1; k <= 8 * eff + 2; k++) begin
        tick(1);
        if (k == 1) period_i = PW'(p + 3);
        if (k / eff >= 4) chk("R4 wrap", ss_o, (k / eff) % 4);
        else              chk("R3 step", ss_o, k / eff);
      end
      chk("R2 period kept", ss_o, ((8 * eff + 2) / eff) % 4);
    end

    // R5: carrier loss pauses code and dwell count
    do_reset(3);
    tick(4);
    chk("R3 pre-pause", ss_o, 1);
    carrier_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      chk("R5 hold", ss_o, 1);
    end
    carrier_i = 1'b1;
    tick(1);
    chk("R5 resume partial", ss_o, 1);
    tick(1);
    chk("R5 resume step", ss_o, 2);

    // R6/R7/R8: lock, restart, timeout
    trs_valid_i = 1'b1;
    tick(1);
    trs_valid_i = 1'b0;
    chk("R6 locked", locked_o, 1);
    chk("R6 code", ss_o, 2);
    carrier_i = 1'b0;
    tick(2);
    chk("R7 locked no carrier", locked_o, 1);
    chk("R7 code no carrier", ss_o, 2);
    carrier_i = 1'b1;
    tick(1);
    trs_valid_i = 1'b1;
    tick(1);
    trs_valid_i = 1'b0;
    for (int i = 1; i < TO; i++) begin
      tick(1);
      chk("R7 restarted timeout", locked_o, 1);
      chk("R7 code frozen", ss_o, 2);
    end
    tick(1);
    chk("R8 unlock", locked_o, 0);
    chk("R8 code kept", ss_o, 2);
    tick(2);
    chk("R8 full period", ss_o, 2);
    tick(1);
    chk("R8 resumed step", ss_o, 3);
    tick(3);
    chk("R4 wrap after resume", ss_o, 0);

    // R6: TRS locks without carrier
    carrier_i = 1'b0;
    trs_valid_i = 1'b1;
    tick(1);
    trs_valid_i = 1'b0;
    chk("R6 lock without carrier", locked_o, 1);
    chk("R9 code", ss_o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule